// File: doc/BRIEF.md
# Finite-Difference Polynomial Tabulator

This block produces the successive values f(0), f(1), f(2), ... of a polynomial without a single multiplier. It keeps a register for the running value and one register for each order of difference, up to a parameterised highest order (six by default, enough for any polynomial of degree six or less). Every step replaces each register by its own contents plus the register one order above. The value therefore advances by the first difference, each difference advances by the next higher one, and the highest difference never changes.

The starting value and starting differences are computed elsewhere and written one word at a time through a load port, selected by an index. After loading, each accepted step pulse emits the current value together with its position n and a one-cycle valid strobe, and advances all registers in the same clock edge. Arithmetic wraps modulo 2^WIDTH. A sticky flag records any signed two's-complement overflow of the value update.

Top module: `diff_tabulator`

## Requirements
- R1: While and after a synchronous reset (rst high), out_valid, out_val, out_n and ovf_flag are all 0, and every internal register holds 0.
- R2: A write with ld_en high and ld_idx = 0 sets the running value to ld_data, clears the step count to 0 and clears ovf_flag. ld_idx = k with 1 <= k <= ORDER sets difference k. An index above ORDER changes nothing.
- R3: A step is accepted when step is 1 and ld_en is 0. In the next cycle out_valid is 1 for exactly that one cycle.
- R4: An accepted step presents the running value held before the step on out_val, then replaces that value with value + difference 1, modulo 2^WIDTH.
- R5: On an accepted step, difference k (k < ORDER) becomes difference k + difference k+1, and difference ORDER is unchanged. All registers use the values they held before the edge, so steps on consecutive cycles are valid.
- R6: When step is 1 in a cycle where ld_en is 1, the step is ignored: out_valid stays 0 in the following cycle and no register advances.
- R7: out_n carries the count of accepted steps since the last index-0 write (or reset) before this step, so the first output after loading has out_n = 0.
- R8: If the value update of an accepted step overflows as a signed two's-complement sum (operands of equal sign, result of the other sign), ovf_flag is 1 from the next cycle on. It stays 1 until reset or an index-0 write.
- R9: With ORDER = 6, the sequence produced for any degree-6 polynomial whose initial differences are loaded equals direct evaluation of that polynomial modulo 2^WIDTH.
- R10: When no step is accepted, out_val and out_n keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load strobe; a write happens in every cycle it is high |
| ld_idx | input | IDX_W ($clog2(ORDER+1)) | Target: 0 = running value, k = difference order k |
| ld_data | input | WIDTH | Word to be written |
| step | input | 1 | Step request, one per cycle while high |
| out_valid | output | 1 | One-cycle strobe marking a new output |
| out_val | output | WIDTH | Tabulated value f(n) |
| out_n | output | CNT_W | Position n of the value on out_val |
| ovf_flag | output | 1 | Sticky signed-overflow flag of the value update |

## Verification
A load write and a step request can arrive in the same cycle. The bench provokes this by raising step together with a write to an unused index in the middle of a running sequence. It then checks that no strobe follows and that the next real step continues the sequence exactly where it stopped. A second collision pairs an index-0 reload with a flag that is already set, and the bench judges from the ports that the flag clears and the count restarts at zero. The reference compares every cycle against direct evaluation of the polynomial, which is independent of the adder cascade.

// File: rtl/dtab_pkg.sv
package dtab_pkg;

  // Signed overflow of a two's-complement sum, from the sign bits alone.
  function automatic logic sum_ovf(input logic a_msb, input logic b_msb, input logic s_msb);
    return (a_msb == b_msb) && (s_msb != a_msb);
  endfunction

endpackage

// File: rtl/dtab_load_dec.sv
module dtab_load_dec #(
  parameter int ORDER = 6,
  parameter int IDX_W = 3
) (
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  output logic             wr_val,
  output logic [ORDER:1]   wr_diff
);

  assign wr_val = ld_en && (ld_idx == '0);

  for (genvar k = 1; k <= ORDER; k++) begin : g_sel
    assign wr_diff[k] = ld_en && (ld_idx == IDX_W'(k));
  end

endmodule

// File: rtl/dtab_diff_cell.sv
module dtab_diff_cell #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             adv,
  input  logic [WIDTH-1:0] upper,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr) begin
      q <= wr_data;
    end else if (adv) begin
      q <= q + upper;
    end
  end

endmodule

// File: rtl/dtab_value_unit.sv
module dtab_value_unit
  import dtab_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             adv,
  input  logic [WIDTH-1:0] d1,
  output logic [WIDTH-1:0] out_val,
  output logic [CNT_W-1:0] out_n,
  output logic             out_vld,
  output logic             ovf
);

  logic [WIDTH-1:0] acc;
  logic [CNT_W-1:0] cnt;
  logic [WIDTH-1:0] nxt;
  logic             nxt_ovf;

  assign nxt     = acc + d1;
  assign nxt_ovf = sum_ovf(acc[WIDTH-1], d1[WIDTH-1], nxt[WIDTH-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      cnt     <= '0;
      out_val <= '0;
      out_n   <= '0;
      out_vld <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      out_vld <= adv;
      if (wr) begin
        acc <= wr_data;
        cnt <= '0;
        ovf <= 1'b0;
      end else if (adv) begin
        acc     <= nxt;
        cnt     <= cnt + 1'b1;
        out_val <= acc;
        out_n   <= cnt;
        if (nxt_ovf) ovf <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/diff_tabulator.sv
module diff_tabulator #(
  parameter  int WIDTH = 32,
  parameter  int ORDER = 6,
  parameter  int CNT_W = 32,
  localparam int IDX_W = $clog2(ORDER + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [WIDTH-1:0] ld_data,
  input  logic             step,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_val,
  output logic [CNT_W-1:0] out_n,
  output logic             ovf_flag
);

  logic             wr_val;
  logic [ORDER:1]   wr_diff;
  logic             adv;
  logic [WIDTH-1:0] diff_q [1:ORDER];

  // A load in progress always wins over a step request.
  assign adv = step && !ld_en;

  dtab_load_dec #(.ORDER(ORDER), .IDX_W(IDX_W)) dec_i (
    .ld_en   (ld_en),
    .ld_idx  (ld_idx),
    .wr_val  (wr_val),
    .wr_diff (wr_diff)
  );

  for (genvar k = 1; k <= ORDER; k++) begin : g_ord
    logic [WIDTH-1:0] upper;
    if (k < ORDER) begin : g_mid
      assign upper = diff_q[k+1];
    end else begin : g_top
      assign upper = '0;
    end
    dtab_diff_cell #(.WIDTH(WIDTH)) cell_i (
      .clk     (clk),
      .rst     (rst),
      .wr      (wr_diff[k]),
      .wr_data (ld_data),
      .adv     (adv),
      .upper   (upper),
      .q       (diff_q[k])
    );
  end

  dtab_value_unit #(.WIDTH(WIDTH), .CNT_W(CNT_W)) val_i (
    .clk     (clk),
    .rst     (rst),
    .wr      (wr_val),
    .wr_data (ld_data),
    .adv     (adv),
    .d1      (diff_q[1]),
    .out_val (out_val),
    .out_n   (out_n),
    .out_vld (out_valid),
    .ovf     (ovf_flag)
  );

endmodule

// File: rtl/dtab_chk.sv
module dtab_chk #(
  parameter int WIDTH = 32,
  parameter int CNT_W = 32,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ld_en,
  input logic [IDX_W-1:0] ld_idx,
  input logic             step,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_val,
  input logic [CNT_W-1:0] out_n,
  input logic             ovf_flag
);

  logic [CNT_W-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (ld_en && ld_idx == '0) seen <= '0;
    else if (step && !ld_en) seen <= seen + 1'b1;
  end

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (!out_valid && !ovf_flag && out_n == '0 && out_val == '0)); // R1

  AST_ZERO_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ld_en && ld_idx == '0) |=> !ovf_flag); // R2

  AST_STEP_STROBE: assert property (@(posedge clk) disable iff (rst)
    (step && !ld_en) |=> out_valid); // R3

  AST_LOAD_BLOCKS_STEP: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> !out_valid); // R6

  AST_COUNT_SEQ: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_n == CNT_W'(seen - 1'b1))); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !(ld_en && ld_idx == '0)) |=> ovf_flag); // R8

  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    !(step && !ld_en) |=> ($stable(out_val) && $stable(out_n))); // R10

endmodule

bind diff_tabulator dtab_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .ld_en     (ld_en),
  .ld_idx    (ld_idx),
  .step      (step),
  .out_valid (out_valid),
  .out_val   (out_val),
  .out_n     (out_n),
  .ovf_flag  (ovf_flag)
);

// File: tb/diff_tabulator_tb_top.sv
`timescale 1ns/1ps
module diff_tabulator_tb_top;

  typedef logic [31:0] cvec_t [0:6];

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_idx = '0;
  logic [31:0] ld_data = '0;
  logic        step = 1'b0;
  logic        out_valid;
  logic [31:0] out_val;
  logic [31:0] out_n;
  logic        ovf_flag;

  int checks = 0;
  int fails  = 0;
  bit chk_on = 1'b0;

  cvec_t       cur;
  logic [31:0] pos = '0;
  logic        m_vld = 1'b0;
  logic [31:0] m_val = '0;
  logic [31:0] m_n = '0;
  logic        m_ovf = 1'b0;

  always #2 clk = ~clk;

  diff_tabulator dut_i (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .step(step), .out_valid(out_valid), .out_val(out_val), .out_n(out_n),
    .ovf_flag(ovf_flag)
  );

  function automatic logic [31:0] peval(input cvec_t c, input logic [31:0] n);
    logic [31:0] a = '0;
    for (int i = 6; i >= 0; i--) a = a * n + c[i];
    return a;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: expected outputs from direct polynomial evaluation.
  always @(posedge clk) begin
    if (rst) begin
      m_vld <= 1'b0; m_val <= '0; m_n <= '0; m_ovf <= 1'b0; pos <= '0;
    end else begin
      m_vld <= step && !ld_en;
      if (ld_en && ld_idx == 3'd0) begin
        pos <= '0; m_ovf <= 1'b0;
      end else if (step && !ld_en) begin
        logic [31:0] a, b, d;
        a = peval(cur, pos);
        b = peval(cur, pos + 1);
        d = b - a;
        m_val <= a; m_n <= pos; pos <= pos + 1;
        if (a[31] == d[31] && b[31] != a[31]) m_ovf <= 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      check(out_valid == m_vld, "R3 valid", 64'(out_valid), 64'(m_vld));
      if (m_vld) begin
        check(out_val == m_val, "R4 value", 64'(out_val), 64'(m_val));
        check(out_n == m_n, "R7 count", 64'(out_n), 64'(m_n));
      end
      check(ovf_flag == m_ovf, "R8 overflow", 64'(ovf_flag), 64'(m_ovf));
    end
  end

  task automatic write(input logic [2:0] idx, input logic [31:0] data);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = idx; ld_data = data; step = 1'b0;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic load_poly(input cvec_t c);
    logic [31:0] t [0:6];
    cur = c;
    for (int i = 0; i <= 6; i++) t[i] = peval(c, 32'(i));
    write(3'd0, t[0]);
    for (int k = 1; k <= 6; k++) begin
      for (int i = 0; i <= 6 - k; i++) t[i] = t[i+1] - t[i];
      write(3'(k), t[0]);
    end
  endtask

  task automatic pulse();
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b0;
  endtask

  task automatic run(input int n);
    @(negedge clk); step = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); step = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] lit [0:4];
    cvec_t q, h, o;
    lit = '{32'd41, 32'd43, 32'd47, 32'd53, 32'd61};
    q = '{32'd41, 32'd1, 32'd1, 32'd0, 32'd0, 32'd0, 32'd0};
    h = '{32'd5, -32'sd3, 32'd0, 32'd2, 32'd0, -32'sd1, 32'd1};
    o = '{32'h7FFF_FFF0, 32'd8, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0};

    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 valid", 64'(out_valid), 0);
    check(out_val == '0, "R1 value", 64'(out_val), 0);
    check(out_n == '0, "R1 count", 64'(out_n), 0);
    check(ovf_flag == 1'b0, "R1 ovf", 64'(ovf_flag), 0);
    rst = 1'b0;
    @(negedge clk);
    chk_on = 1'b1;

    // R4 R5: quadratic, literal sequence
    load_poly(q);
    for (int i = 0; i < 5; i++) begin
      pulse();
      check(out_valid && out_val == lit[i], "R5 literal", 64'(out_val), 64'(lit[i]));
    end
    // R10: hold while idle
    repeat (3) @(negedge clk);
    check(out_val == 32'd61 && out_n == 32'd4, "R10 hold", 64'(out_val), 64'd61);

    // R6: step together with a write to an unused index (R2 ignored index)
    @(negedge clk); ld_en = 1'b1; ld_idx = 3'd7; ld_data = 32'hDEAD_BEEF; step = 1'b1;
    @(negedge clk); ld_en = 1'b0; step = 1'b0;
    check(out_valid == 1'b0, "R6 no strobe", 64'(out_valid), 0);
    pulse();
    check(out_val == 32'd71 && out_n == 32'd5, "R2 unused index", 64'(out_val), 64'd71);

    // R5: back-to-back steps
    run(4);
    check(out_val == 32'd131 && out_n == 32'd9, "R5 consecutive", 64'(out_val), 64'd131);

    // R9: degree-6 polynomial
    load_poly(h);
    run(20);
    check(out_val == peval(h, 32'd19), "R9 degree six", 64'(out_val), 64'(peval(h, 32'd19)));

    // R8: signed overflow, wrap and sticky flag
    load_poly(o);
    run(3);
    @(negedge clk);
    check(ovf_flag == 1'b1, "R8 flag set", 64'(ovf_flag), 1);
    check(out_val == 32'h8000_0000, "R8 wrap", 64'(out_val), 64'h8000_0000);
    repeat (2) @(negedge clk);
    check(ovf_flag == 1'b1, "R8 sticky", 64'(ovf_flag), 1);

    // R2 R7: reload clears flag and restarts count
    load_poly(q);
    check(ovf_flag == 1'b0, "R2 flag cleared", 64'(ovf_flag), 0);
    pulse();
    check(out_n == 32'd0 && out_val == 32'd41, "R7 restart", 64'(out_n), 0);
    run(6);
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule